// File: doc/BRIEF.md
# Peripheral Clock Gating Register

This block holds a 32-bit enable word with one bit per peripheral slot. Slot N is the peripheral at index N of the peripheral address map. Each slot has its own clock output. A slot whose bit is set receives the source clock. A slot whose bit is clear has its clock held low to save power. A few slots carry housekeeping functions, such as the watchdog, the general-purpose I/O, the pin multiplexer and system control. These slots are named in a parameter mask and always receive the clock, whatever their bit holds. Each gated slot passes its enable through a cell that is transparent while the clock is low, followed by an AND gate. An enable change therefore never shortens or splits a clock pulse.

The same block watches the register bus on its way to the peripherals. The address decoder supplies a select vector that names the slot an access is aimed at. An access to a slot whose clock is running is passed through. Its write and read strobes reach the peripheral in the same cycle, and the read data comes back one cycle later. An access to a slot whose clock is stopped has its strobes suppressed, returns zero, and raises an error flag for one cycle. The enable word itself sits at one bus address and is read and written through the same port. A write reaches the clock gates on the clock cycle after it is stored.

Top module: `pclk_gate_ctrl`

## Requirements
- R1: After reset, the enable word holds `RESET_MASK` (default 32'h0000_0F0F), and a read of the control address returns that value.
- R2: A write at address `CTRL_ADDR` (default 8'hC4) stores all 32 bits of the write data. A later read of that address returns them on `bus_rdata` in the cycle after the read, with `bus_err` low.
- R3: For a slot not in `ALWAYS_ON_MASK`, `gclk[N]` follows `clk` while bit N of the enable word is 1 and stays low while bit N is 0.
- R4: Slots set in `ALWAYS_ON_MASK` (default slots 0, 1 and 4) receive `clk` on `gclk` whatever their enable bit holds.
- R5: A write that is captured at rising edge k does not change the clock pulse that starts at edge k. The pulse that starts at edge k+1 already follows the new value.
- R6: No `gclk` output is ever high while `clk` is low.
- R7: An access with `periph_sel` naming an enabled slot raises `periph_we`/`periph_re` combinationally with `bus_we`/`bus_re`. For a read, the `periph_rdata` present in the access cycle appears on `bus_rdata` one cycle later, with `bus_err` low.
- R8: An access to a slot whose clock is gated off keeps `periph_we` and `periph_re` low. In the next cycle it returns `bus_rdata` = 0 and `bus_err` = 1. `bus_err` stays high only for cycles that follow such an access.
- R9: Accesses to an always-on slot are forwarded even when its enable bit is 0.
- R10: An access with no bit of `periph_sel` set, at an address other than `CTRL_ADDR`, is not forwarded. It raises no error and reads as zero.
- R11: An access at `CTRL_ADDR` never raises `periph_we` or `periph_re`, even when `periph_sel` is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock for the register and all slot clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address of the current access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| periph_sel | input | 32 | Slot select from the address decoder, one bit per slot |
| periph_rdata | input | 32 | Read data returned by the selected peripheral |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle flag for an access to a gated-off slot |
| periph_we | output | 1 | Write strobe forwarded to the selected peripheral |
| periph_re | output | 1 | Read strobe forwarded to the selected peripheral |
| gclk | output | 32 | Per-slot gated clock |

## Verification
A wrong bit in the enable word becomes visible at the ports within a clock cycle. It shows on the matching `gclk` output, whose pulses appear or vanish one edge after the bad value is stored. It also shows on the next access to that slot, through a forwarded or dropped strobe in the same cycle and an error flag one cycle later. A latch that captures at the wrong phase would show as a clipped or early pulse. The bench therefore samples each slot clock in both clock phases around every enable change. A stale error or read-data register would leak into the following idle or permitted access, so the bench also checks every idle cycle for a quiet error flag.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam int REG_W = 32;

    typedef logic [REG_W-1:0] word_t;

    // Registered state of the control block: enable word and bus response.
    typedef struct packed {
        word_t en;
        word_t rdata;
        logic  err;
    } pcg_state_t;
endpackage

// File: rtl/pcg_clk_gate.sv
// Behavioural clock-gate cell: enable sampled while the clock is low.
module pcg_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_lat;

    always_latch begin
        if (!clk_i) begin
            en_lat = en_i;
        end
    end

    assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/pcg_access_guard.sv
// Qualifies bus accesses against the effective slot enables.
module pcg_access_guard #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hC4
) (
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      we_i,
    input  logic                      re_i,
    input  logic [pcg_pkg::REG_W-1:0] sel_i,
    input  logic [pcg_pkg::REG_W-1:0] en_eff_i,
    output logic                      hit_o,
    output logic                      fwd_we_o,
    output logic                      fwd_re_o,
    output logic                      blocked_o
);
    logic access;
    logic target_on;
    logic any_sel;

    always_comb begin
        hit_o     = (addr_i == CTRL_ADDR);
        access    = we_i | re_i;
        any_sel   = |sel_i;
        target_on = |(sel_i & en_eff_i);
        fwd_we_o  = we_i & ~hit_o & target_on;
        fwd_re_o  = re_i & ~hit_o & target_on;
        blocked_o = access & ~hit_o & any_sel & ~target_on;
    end
endmodule

// File: rtl/pcg_ctrl_reg.sv
// Enable word plus registered bus response, two-process form.
module pcg_ctrl_reg
    import pcg_pkg::*;
#(
    parameter word_t RESET_MASK = 32'h0000_0F0F
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hit_i,
    input  logic  we_i,
    input  logic  re_i,
    input  word_t wdata_i,
    input  logic  fwd_re_i,
    input  logic  blocked_i,
    input  word_t periph_rdata_i,
    output word_t en_o,
    output word_t rdata_o,
    output logic  err_o
);
    pcg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = blocked_i;
        if (hit_i && we_i) begin
            st_d.en = wdata_i;
        end
        if (hit_i && re_i) begin
            st_d.rdata = st_q.en;
        end else if (fwd_re_i) begin
            st_d.rdata = periph_rdata_i;
        end else begin
            st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: RESET_MASK, rdata: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign rdata_o = st_q.rdata;
    assign err_o   = st_q.err;
endmodule

// File: rtl/pclk_gate_ctrl.sv
// Peripheral clock gating register with access blocking.
module pclk_gate_ctrl
    import pcg_pkg::*;
#(
    parameter int                ADDR_W         = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR      = 8'hC4,
    parameter word_t             RESET_MASK     = 32'h0000_0F0F,
    parameter word_t             ALWAYS_ON_MASK = 32'h0000_0013
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [REG_W-1:0]  periph_sel,
    input  logic [REG_W-1:0]  periph_rdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_err,
    output logic              periph_we,
    output logic              periph_re,
    output logic [REG_W-1:0]  gclk
);
    word_t en_q;
    word_t en_eff;
    logic  hit;
    logic  fwd_re;
    logic  blocked;

    assign en_eff = en_q | ALWAYS_ON_MASK;

    pcg_access_guard #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_guard (
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .re_i     (bus_re),
        .sel_i    (periph_sel),
        .en_eff_i (en_eff),
        .hit_o    (hit),
        .fwd_we_o (periph_we),
        .fwd_re_o (fwd_re),
        .blocked_o(blocked)
    );

    assign periph_re = fwd_re;

    pcg_ctrl_reg #(
        .RESET_MASK(RESET_MASK)
    ) u_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .hit_i         (hit),
        .we_i          (bus_we),
        .re_i          (bus_re),
        .wdata_i       (bus_wdata),
        .fwd_re_i      (fwd_re),
        .blocked_i     (blocked),
        .periph_rdata_i(periph_rdata),
        .en_o          (en_q),
        .rdata_o       (bus_rdata),
        .err_o         (bus_err)
    );

    // Always-on slots take the source clock directly; others get a gate cell.
    for (genvar g = 0; g < REG_W; g++) begin : g_slot
        if (ALWAYS_ON_MASK[g]) begin : g_aon
            assign gclk[g] = clk;
        end else begin : g_gated
            pcg_clk_gate u_cg (
                .clk_i (clk),
                .en_i  (en_eff[g]),
                .gclk_o(gclk[g])
            );
        end
    end
endmodule

// File: rtl/pcg_checker.sv
// Property checker for pclk_gate_ctrl, attached by bind below.
module pcg_checker #(
    parameter int                ADDR_W         = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR      = 8'hC4,
    parameter logic [31:0]       ALWAYS_ON_MASK = 32'h0000_0013
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       periph_sel,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              periph_we,
    input logic              periph_re,
    input logic [31:0]       gclk,
    input logic [31:0]       en_q
);
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CTRL_ADDR) |=> (en_q == $past(bus_wdata)));

    p_aon_run_r4: assert property (@(negedge clk) disable iff (!rst_n)
        ((gclk & ALWAYS_ON_MASK) == ALWAYS_ON_MASK));

    // Sampled just before each rising edge, i.e. at the end of the low phase.
    p_gate_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gclk == '0));

    p_fwd_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_we || periph_re) |-> (|(periph_sel & (en_q | ALWAYS_ON_MASK))));

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past((bus_we || bus_re) && bus_addr != CTRL_ADDR && periph_sel != '0));

    p_err_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));

    p_ctrl_no_fwd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CTRL_ADDR) |-> (!periph_we && !periph_re));
endmodule

bind pclk_gate_ctrl pcg_checker #(
    .ADDR_W        (ADDR_W),
    .CTRL_ADDR     (CTRL_ADDR),
    .ALWAYS_ON_MASK(ALWAYS_ON_MASK)
) u_pcg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .periph_sel  (periph_sel),
    .bus_rdata   (bus_rdata),
    .bus_err     (bus_err),
    .periph_we   (periph_we),
    .periph_re   (periph_re),
    .gclk        (gclk),
    .en_q        (en_q)
);

// File: tb/pclk_gate_ctrl_tb_top.sv
module pclk_gate_ctrl_tb_top;
    localparam logic [7:0]  CA  = 8'hC4;
    localparam logic [31:0] RST = 32'h0000_0F0F;
    localparam logic [31:0] AON = 32'h0000_0013;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] periph_sel = '0;
    logic [31:0] periph_rdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        periph_we;
    logic        periph_re;
    logic [31:0] gclk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pclk_gate_ctrl #(
        .ADDR_W(8), .CTRL_ADDR(CA), .RESET_MASK(RST), .ALWAYS_ON_MASK(AON)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .periph_sel(periph_sel),
        .periph_rdata(periph_rdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .periph_we(periph_we), .periph_re(periph_re), .gclk(gclk)
    );

    typedef struct {
        logic [31:0] rd;
        logic        err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] slot(input int n);
        return 32'h1 << n;
    endfunction

    function automatic logic [31:0] pdata(input int n);
        return 32'h5A00_0000 | n;
    endfunction

    // Driver: one access per call, starting on the falling edge.
    task automatic op(input logic [7:0] a, input logic w, input logic r,
                      input logic [31:0] wd, input logic [31:0] sel,
                      input logic [31:0] prd, input logic [31:0] exp_rd,
                      input logic exp_err, input logic exp_fw, input logic exp_fr,
                      input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr = a; bus_we = w; bus_re = r; bus_wdata = wd;
        periph_sel = sel; periph_rdata = prd;
        #1;
        check(periph_we == exp_fw, {tag, " periph_we"}, {31'b0, periph_we}, {31'b0, exp_fw});
        check(periph_re == exp_fr, {tag, " periph_re"}, {31'b0, periph_re}, {31'b0, exp_fr});
        e.rd = exp_rd; e.err = exp_err; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0; periph_sel = '0; bus_addr = '0;
    endtask

    task automatic chk_gclk(input logic [31:0] exp, input string tag);
        check(gclk == exp, {tag, " gclk"}, gclk, exp);
    endtask

    // Monitor: compares each registered response, and idle cycles for a quiet error flag.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(bus_rdata == e.rd, {e.tag, " rdata"}, bus_rdata, e.rd);
                check(bus_err == e.err, {e.tag, " err"}, {31'b0, bus_err}, {31'b0, e.err});
            end else if (rst_n) begin
                check(bus_err == 1'b0, "R8 idle err", {31'b0, bus_err}, 32'h0);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #5;
        chk_gclk(RST | AON, "R1 R3 R4 reset");
        @(negedge clk); #5;
        chk_gclk(32'h0, "R6 low phase");

        op(CA, 0, 1, '0, '0, '0, RST, 0, 0, 0, "R1 read reset value");

        // Clear every bit; only always-on slots keep running.
        op(CA, 1, 0, 32'h0, '0, '0, 32'h0, 0, 0, 0, "R2 write zero");
        #5 chk_gclk(RST | AON, "R5 old value at capture edge");
        idle();
        @(posedge clk); #5;
        chk_gclk(AON, "R5 R4 new value next edge");
        @(negedge clk); #5;
        chk_gclk(32'h0, "R6 low phase after change");

        op(CA, 0, 1, '0, '0, '0, 32'h0, 0, 0, 0, "R2 read back zero");
        op(8'h20, 0, 1, '0, slot(2), pdata(2), 32'h0, 1, 0, 0, "R8 blocked read");
        op(8'h24, 1, 0, 32'hDEAD_BEEF, slot(5), '0, 32'h0, 1, 0, 0, "R8 blocked write");
        op(8'h28, 0, 1, '0, slot(1), pdata(1), pdata(1), 0, 0, 1, "R9 always-on read");
        op(8'h2C, 1, 0, 32'h1234, slot(4), '0, 32'h0, 0, 1, 0, "R9 always-on write");

        // Control write with a stale select: must not reach a peripheral.
        op(CA, 1, 0, 32'hA5A5_0024, slot(2), '0, 32'h0, 0, 0, 0, "R11 ctrl write");
        op(CA, 0, 1, '0, slot(5), pdata(5), 32'hA5A5_0024, 0, 0, 0, "R2 R11 ctrl read");
        idle();
        @(posedge clk); #5;
        chk_gclk(32'hA5A5_0024 | AON, "R3 pattern");

        op(8'h30, 0, 1, '0, slot(2), pdata(2), pdata(2), 0, 0, 1, "R7 read enabled");
        op(8'h34, 1, 0, 32'h77, slot(5), '0, 32'h0, 0, 1, 0, "R7 write enabled");
        op(8'h10, 0, 1, '0, '0, pdata(9), 32'h0, 0, 0, 0, "R10 no select read");
        op(8'h14, 1, 0, 32'h1, '0, '0, 32'h0, 0, 0, 0, "R10 no select write");
        op(8'h38, 0, 1, '0, slot(3), pdata(3), 32'h0, 1, 0, 0, "R8 blocked slot3");
        op(8'h38, 0, 1, '0, slot(2), pdata(2), pdata(2), 0, 0, 1, "R8 error drops after one cycle");

        op(CA, 1, 0, 32'hFFFF_FFFF, '0, '0, 32'h0, 0, 0, 0, "R2 write all ones");
        #5 chk_gclk(32'hA5A5_0024 | AON, "R5 old value at capture edge 2");
        idle();
        @(posedge clk); #5;
        chk_gclk(32'hFFFF_FFFF, "R3 all running");
        @(negedge clk); #5;
        chk_gclk(32'h0, "R6 low phase all on");
        op(8'h38, 0, 1, '0, slot(3), pdata(3), pdata(3), 0, 0, 1, "R7 slot3 now enabled");
        op(CA, 0, 1, '0, '0, '0, 32'hFFFF_FFFF, 0, 0, 0, "R2 read all ones");
        idle();
        repeat (3) @(posedge clk);
        #5;
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule